// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block moves outgoing frame data from memory to a byte stream by walking a ring of descriptors that software prepares. Each descriptor is two 32-bit words: a buffer base address and a control word. Software fills descriptors, clears their ownership flag and pulses a start request. The engine fetches descriptors one after another and streams each buffer's bytes in address order. When a frame ends, it hands the frame back by setting the ownership flag in the control word of the frame's first descriptor.

The engine stops when it meets a descriptor that software still owns. It can also stop because of an error. An error is a buffer memory that starves the stream in mid-frame, or a descriptor that software still owns appearing before a frame is complete. In both cases the engine records the cause in the same control word it hands back. A halt request lets the frame in flight finish and then parks the engine. The ring index survives between runs, so each run resumes at the next descriptor.

Control word layout: bits 10:0 hold the buffer byte count. Bit 15 marks the last buffer of a frame. Bit 16 asks that no checksum be appended. Bit 27 reports a frame cut short by an owned descriptor. Bit 28 reports starvation. Bit 30 is the ring-end marker. Bit 31 is the ownership flag, where 1 means software owns the descriptor.

Top module: `txdesc_ring_reader`

## Requirements
- R1: After reset `tx_go` is low, no memory request or stream beat is issued, and the first run fetches descriptor slot 0.
- R2: A `tx_start` pulse while idle raises `tx_go` on the next cycle and starts fetching at the held ring index. A pulse while running has no effect. The index is kept from one run to the next.
- R3: If the engine reads a control word with bit 31 set while no frame is open, it stops without writing anything back and `tx_go` falls. The index stays on that slot.
- R4: Each descriptor supplies the byte count in control bits 10:0. Those bytes are streamed from consecutive byte addresses starting at the address word. A descriptor with a count of zero adds no bytes. One buffer read is issued at a time.
- R5: A frame is the run of descriptors up to and including the one with bit 15 set. `st_last` marks its final byte. After that byte is accepted, the control word of the frame's first descriptor is written back as its fetched value with bit 31 set. No other control word of the frame is written.
- R6: After a descriptor with bit 30 set, or after the last ring slot, the next descriptor fetched is slot 0.
- R7: `st_nocrc` equals bit 16 of the frame's first control word on every byte of that frame.
- R8: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data`, `st_last` and `st_nocrc` hold steady.
- R9: If at least one byte of a frame has been delivered and a buffer read then goes unanswered for `STARVE_LIM` cycles, the first control word is written back with bits 31 and 28 set, the frame is dropped and the engine stops.
- R10: If a control word with bit 31 set is read inside an open frame, the first control word is written back with bits 31 and 27 set and the engine stops.
- R11: A `tx_halt` pulse while running lets the current frame finish, and `tx_go` stays high until then. The engine then stops before starting the next frame and keeps its index.
- R12: Slot s has its address word at descriptor word address 2*s and its control word at 2*s+1. Read data returns one cycle after `dsc_rd_en`. Reads and writes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start request pulse |
| tx_halt | input | 1 | Halt request pulse |
| tx_go | output | 1 | Engine running |
| dsc_rd_en | output | 1 | Descriptor word read |
| dsc_wr_en | output | 1 | Descriptor word write |
| dsc_addr | output | IDX_W+1 | Descriptor word address |
| dsc_wdata | output | 32 | Write-back control word |
| dsc_rdata | input | 32 | Read data, one cycle after the read |
| buf_rd_en | output | 1 | Buffer byte read request |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_rvalid | input | 1 | Buffer byte returned |
| buf_rdata | input | 8 | Buffer byte |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of frame |
| st_nocrc | output | 1 | Frame asks for no checksum |
| st_ready | input | 1 | Stream sink ready |

## Verification
The bench targets the following cases:
- A zero-length middle buffer. A design that mishandled it would emit a byte or lose the frame end.
- The ring-end marker. If it were ignored, fetching would run on to slot 6 instead of slot 0.
- Wrap after the last slot with no marker, exercised by random rounds.
- Start pulses sent mid-frame, which must not restart the run.
- A halt that arrives mid-frame. A wrong design would truncate that frame or go on to send the next one.
- Starvation, which must produce a bit-28 write-back after exactly the delivered bytes.
- An owned descriptor inside a frame, which must produce a bit-27 write-back rather than a silent stop.
- Write-back scope: a design that wrote back to every descriptor of the frame would corrupt the middle control words, which the bench compares.

// File: rtl/txdr_pkg.sv
package txdr_pkg;
  localparam int CW_OWNED  = 31;
  localparam int CW_RING_END = 30;
  localparam int CW_STARVED = 28;
  localparam int CW_SHORT  = 27;
  localparam int CW_NOCRC  = 16;
  localparam int CW_FEND   = 15;
  localparam int LEN_W     = 11;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_RD_CTRL, S_DECODE, S_BREQ, S_BWAIT, S_BOUT, S_WBACK
  } txdr_state_e;
endpackage

// File: rtl/txdr_ring_idx.sv
module txdr_ring_idx #(
  parameter int RING_N = 8,
  localparam int IDX_W = $clog2(RING_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             wrap_req,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_N - 1);
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    if (wrap_req || idx == LAST_SLOT) idx_nxt = '0;
    else                              idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (adv_en) idx <= idx_nxt;
  end
endmodule

// File: rtl/txdr_starve_mon.sv
module txdr_starve_mon #(
  parameter int STARVE_LIM = 8,
  localparam int CNT_W = $clog2(STARVE_LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch,
  output logic starve
);
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = watch ? cnt + 1'b1 : '0;
    starve  = watch && (cnt == CNT_W'(STARVE_LIM - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/txdesc_ring_reader.sv
module txdesc_ring_reader #(
  parameter int RING_N     = 8,
  parameter int STARVE_LIM = 8,
  parameter int ADDR_W     = 32,
  localparam int IDX_W     = $clog2(RING_N),
  localparam int DA_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_halt,
  output logic              tx_go,
  output logic              dsc_rd_en,
  output logic              dsc_wr_en,
  output logic [DA_W-1:0]   dsc_addr,
  output logic [31:0]       dsc_wdata,
  input  logic [31:0]       dsc_rdata,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic              buf_rvalid,
  input  logic [7:0]        buf_rdata,
  output logic              st_valid,
  output logic [7:0]        st_data,
  output logic              st_last,
  output logic              st_nocrc,
  input  logic              st_ready
);
  import txdr_pkg::*;

  txdr_state_e      state, state_nxt;
  logic [ADDR_W-1:0] ptr, ptr_nxt;
  logic [LEN_W-1:0] cnt, cnt_nxt;
  logic [7:0]       hold, hold_nxt;
  logic [IDX_W-1:0] first_idx, first_idx_nxt;
  logic [31:0]      first_ctrl, first_ctrl_nxt;
  logic             cur_eof, cur_eof_nxt;
  logic             in_frame, in_frame_nxt;
  logic             sent_any, sent_any_nxt;
  logic             halt_pend, halt_pend_nxt;
  logic             err_starve, err_starve_nxt;
  logic             err_short, err_short_nxt;
  logic [IDX_W-1:0] idx;
  logic             idx_adv, idx_wrap;
  logic             starve;

  txdr_ring_idx #(.RING_N(RING_N)) u_idx (
    .clk(clk), .rst_n(rst_n), .adv_en(idx_adv), .wrap_req(idx_wrap), .idx(idx)
  );

  txdr_starve_mon #(.STARVE_LIM(STARVE_LIM)) u_starve (
    .clk(clk), .rst_n(rst_n),
    .watch((state == S_BWAIT) && sent_any && !buf_rvalid),
    .starve(starve)
  );

  always_comb begin
    state_nxt      = state;
    ptr_nxt        = ptr;
    cnt_nxt        = cnt;
    hold_nxt       = hold;
    first_idx_nxt  = first_idx;
    first_ctrl_nxt = first_ctrl;
    cur_eof_nxt    = cur_eof;
    in_frame_nxt   = in_frame;
    sent_any_nxt   = sent_any;
    err_starve_nxt = err_starve;
    err_short_nxt  = err_short;
    idx_adv        = 1'b0;
    idx_wrap       = 1'b0;
    dsc_rd_en      = 1'b0;
    dsc_wr_en      = 1'b0;
    dsc_addr       = {idx, 1'b0};
    dsc_wdata      = first_ctrl;
    buf_rd_en      = 1'b0;
    st_valid       = 1'b0;
    st_last        = 1'b0;
    unique case (state)
      S_IDLE: if (tx_start) state_nxt = S_RD_ADDR;
      S_RD_ADDR: begin
        if (!in_frame && halt_pend) state_nxt = S_IDLE;
        else begin
          dsc_rd_en = 1'b1;
          state_nxt = S_RD_CTRL;
        end
      end
      S_RD_CTRL: begin
        ptr_nxt   = dsc_rdata[ADDR_W-1:0];
        dsc_rd_en = 1'b1;
        dsc_addr  = {idx, 1'b1};
        state_nxt = S_DECODE;
      end
      S_DECODE: begin
        if (dsc_rdata[CW_OWNED]) begin
          if (in_frame) begin
            err_short_nxt = 1'b1;
            state_nxt     = S_WBACK;
          end else begin
            state_nxt     = S_IDLE;
          end
        end else begin
          idx_adv     = 1'b1;
          idx_wrap    = dsc_rdata[CW_RING_END];
          cnt_nxt     = dsc_rdata[LEN_W-1:0];
          cur_eof_nxt = dsc_rdata[CW_FEND];
          if (!in_frame) begin
            first_idx_nxt  = idx;
            first_ctrl_nxt = dsc_rdata;
            in_frame_nxt   = 1'b1;
          end
          if (dsc_rdata[LEN_W-1:0] != '0) state_nxt = S_BREQ;
          else if (dsc_rdata[CW_FEND])      state_nxt = S_WBACK;
          else                              state_nxt = S_RD_ADDR;
        end
      end
      S_BREQ: begin
        buf_rd_en = 1'b1;
        state_nxt = S_BWAIT;
      end
      S_BWAIT: begin
        if (buf_rvalid) begin
          hold_nxt  = buf_rdata;
          state_nxt = S_BOUT;
        end else if (starve) begin
          err_starve_nxt = 1'b1;
          state_nxt      = S_WBACK;
        end
      end
      S_BOUT: begin
        st_valid = 1'b1;
        st_last  = cur_eof && (cnt == LEN_W'(1));
        if (st_ready) begin
          sent_any_nxt = 1'b1;
          cnt_nxt      = cnt - 1'b1;
          ptr_nxt      = ptr + 1'b1;
          if (cnt == LEN_W'(1)) state_nxt = cur_eof ? S_WBACK : S_RD_ADDR;
          else                  state_nxt = S_BREQ;
        end
      end
      S_WBACK: begin
        dsc_wr_en = 1'b1;
        dsc_addr  = {first_idx, 1'b1};
        dsc_wdata = first_ctrl;
        dsc_wdata[CW_OWNED]   = 1'b1;
        dsc_wdata[CW_STARVED] = first_ctrl[CW_STARVED] | err_starve;
        dsc_wdata[CW_SHORT]   = first_ctrl[CW_SHORT] | err_short;
        in_frame_nxt   = 1'b0;
        sent_any_nxt   = 1'b0;
        err_starve_nxt = 1'b0;
        err_short_nxt  = 1'b0;
        state_nxt      = (err_starve || err_short) ? S_IDLE : S_RD_ADDR;
      end
      default: state_nxt = S_IDLE;
    endcase
    halt_pend_nxt = (state_nxt == S_IDLE) ? 1'b0 : (halt_pend || (tx_halt && state != S_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ptr        <= '0;
      cnt        <= '0;
      hold       <= '0;
      first_idx  <= '0;
      first_ctrl <= '0;
      cur_eof    <= 1'b0;
      in_frame   <= 1'b0;
      sent_any   <= 1'b0;
      halt_pend  <= 1'b0;
      err_starve <= 1'b0;
      err_short  <= 1'b0;
    end else begin
      state      <= state_nxt;
      ptr        <= ptr_nxt;
      cnt        <= cnt_nxt;
      hold       <= hold_nxt;
      first_idx  <= first_idx_nxt;
      first_ctrl <= first_ctrl_nxt;
      cur_eof    <= cur_eof_nxt;
      in_frame   <= in_frame_nxt;
      sent_any   <= sent_any_nxt;
      halt_pend  <= halt_pend_nxt;
      err_starve <= err_starve_nxt;
      err_short  <= err_short_nxt;
    end
  end

  assign tx_go    = (state != S_IDLE);
  assign buf_addr = ptr;
  assign st_data  = hold;
  assign st_nocrc = st_valid && first_ctrl[CW_NOCRC];
endmodule

// File: rtl/txdr_chk.sv
module txdr_chk #(
  parameter int DA_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_start,
  input logic            tx_go,
  input logic            dsc_rd_en,
  input logic            dsc_wr_en,
  input logic [DA_W-1:0] dsc_addr,
  input logic [31:0]     dsc_wdata,
  input logic            buf_rd_en,
  input logic            st_valid,
  input logic            st_ready,
  input logic [7:0]      st_data,
  input logic            st_last,
  input logic            st_nocrc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_go |-> !(dsc_rd_en || dsc_wr_en || buf_rd_en || st_valid)); // R3

  AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_go && tx_start |=> tx_go); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last) && $stable(st_nocrc)); // R8

  AST_WBACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_wr_en |-> dsc_wdata[31] && dsc_addr[0]); // R5

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsc_rd_en && dsc_wr_en)); // R12

  AST_ONE_BYTE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> !buf_rd_en); // R4
endmodule

bind txdesc_ring_reader txdr_chk #(.DA_W(DA_W)) u_txdr_chk (.*);

// File: tb/tb_txdesc_ring_reader.sv
`timescale 1ns/1ps
module tb_txdesc_ring_reader;
  localparam int N = 8;
  localparam int DA_W = 4;
  localparam int LIM = 8;

  logic clk, rst_n, tx_start, tx_halt, tx_go;
  logic dsc_rd_en, dsc_wr_en;
  logic [DA_W-1:0] dsc_addr;
  logic [31:0] dsc_wdata, dsc_rdata;
  logic buf_rd_en, buf_rvalid;
  logic [31:0] buf_addr;
  logic [7:0] buf_rdata, st_data;
  logic st_valid, st_last, st_nocrc, st_ready;

  txdesc_ring_reader #(.RING_N(N), .STARVE_LIM(LIM), .ADDR_W(32)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] dmem [0:2*N-1];
  logic [31:0] exp_ctrl [0:N-1];
  bit exp_on [0:N-1];
  logic [7:0] exp_d [0:1023];
  bit exp_l [0:1023], exp_c [0:1023];
  int exp_n;
  logic [7:0] cap_d [0:1023];
  bit cap_l [0:1023], cap_c [0:1023];
  int cap_n;
  bit fr_nc, record;
  int served, allow_lim;
  bit rd_seen;
  logic [DA_W-1:0] first_rd;
  int nx;

  function automatic logic [7:0] bbyte(input logic [31:0] a);
    return 8'((a * 13) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // descriptor memory model: read data one cycle after the read
  always @(posedge clk) begin
    if (dsc_rd_en) dsc_rdata <= dmem[dsc_addr];
    if (dsc_wr_en) dmem[dsc_addr] <= dsc_wdata;
  end

  // buffer memory model: random latency, can be made to stop answering
  logic pend;
  logic [1:0] lat;
  logic [31:0] paddr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; buf_rvalid <= 1'b0; buf_rdata <= '0; lat <= '0; paddr <= '0;
    end else begin
      buf_rvalid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin
          buf_rvalid <= 1'b1; buf_rdata <= bbyte(paddr); pend <= 1'b0;
        end else lat <= lat - 1'b1;
      end
      if (buf_rd_en && served < allow_lim) begin
        pend <= 1'b1; paddr <= buf_addr; lat <= 2'($urandom % 3);
        served <= served + 1;
      end
    end
  end

  always @(posedge clk) st_ready <= ($urandom % 4) != 0;

  // stream capture and stall checks, sampled on the falling edge
  logic pv, pr;
  logic [7:0] pd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_valid && st_ready && cap_n < 1024) begin
        cap_d[cap_n] = st_data; cap_l[cap_n] = st_last; cap_c[cap_n] = st_nocrc;
        cap_n = cap_n + 1;
      end
      if (pv && !pr) chk(st_valid && st_data == pd, "R8", "stalled byte held", {24'd0, st_data}, {24'd0, pd});
      if (dsc_rd_en && !rd_seen) begin rd_seen = 1'b1; first_rd = dsc_addr; end
    end
    pv = st_valid; pr = st_ready; pd = st_data;
  end

  task automatic clr();
    exp_n = 0; cap_n = 0; record = 1'b1;
    for (int i = 0; i < N; i++) exp_on[i] = 1'b0;
  endtask

  task automatic put_desc(input int slot, input int len, input bit eof,
                          input bit nc, input bit wrap, input bit first);
    logic [31:0] base, ctrl;
    base = 32'(slot * 64 + ($urandom % 32));
    if (first) fr_nc = nc;
    ctrl = 32'(len) | (32'(eof) << 15) | (32'(nc) << 16) | (32'(wrap) << 30);
    dmem[2*slot] = base;
    dmem[2*slot+1] = ctrl;
    exp_on[slot] = 1'b1;
    exp_ctrl[slot] = (first && record) ? (ctrl | 32'h8000_0000) : ctrl;
    if (record)
      for (int i = 0; i < len; i++) begin
        exp_d[exp_n] = bbyte(base + 32'(i));
        exp_l[exp_n] = eof && (i == len - 1);
        exp_c[exp_n] = fr_nc;
        exp_n++;
      end
  endtask

  task automatic put_owned(input int slot);
    dmem[2*slot+1] = 32'h8000_0000;
    exp_on[slot] = 1'b1; exp_ctrl[slot] = 32'h8000_0000;
  endtask

  task automatic pulse_start();
    @(negedge clk) tx_start = 1'b1;
    @(negedge clk) tx_start = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (tx_go && k < 4000) begin @(negedge clk); k++; end
    chk(!tx_go, "R3", "engine stopped", {31'd0, tx_go}, 32'd0);
  endtask

  task automatic run(input bit poke);
    rd_seen = 1'b0;
    pulse_start();
    if (poke) begin
      while (!st_valid) @(negedge clk);
      pulse_start();
      pulse_start();
    end
    wait_idle();
  endtask

  task automatic check_all(input string req);
    chk(cap_n == exp_n, req, "byte count", 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap_d[i] == exp_d[i] && cap_l[i] == exp_l[i] && cap_c[i] == exp_c[i], req,
          "byte/last/nocrc", {22'd0, cap_c[i], cap_l[i], cap_d[i]}, {22'd0, exp_c[i], exp_l[i], exp_d[i]});
    for (int s = 0; s < N; s++)
      if (exp_on[s]) chk(dmem[2*s+1] == exp_ctrl[s], req, "control word", dmem[2*s+1], exp_ctrl[s]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tx_start = 1'b0; tx_halt = 1'b0; rst_n = 1'b0;
    served = 0; allow_lim = 32'h7fff_ffff; cap_n = 0; pv = 0; pr = 0; pd = 0; rd_seen = 0;
    for (int s = 0; s < N; s++) begin dmem[2*s] = '0; dmem[2*s+1] = 32'h8000_0000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_go && !dsc_rd_en && !buf_rd_en && !st_valid, "R1", "quiet after reset",
        {28'd0, tx_go, dsc_rd_en, buf_rd_en, st_valid}, 32'd0);

    // R4 R5 R12: single buffer frame from slot 0
    clr(); put_desc(0, 5, 1, 0, 0, 1); put_owned(1);
    run(0);
    chk(first_rd == 4'd0, "R1", "first fetch word (R12 slot 0 word 0)", 32'(first_rd), 32'd0);
    check_all("R4/R5"); nx = 1;

    // R2 index kept, start ignored mid-run; R7 nocrc; zero-length middle buffer
    clr(); put_desc(1, 3, 0, 1, 0, 1); put_desc(2, 0, 0, 0, 0, 0);
    put_desc(3, 4, 1, 0, 0, 0); put_owned(4);
    run(1);
    chk(first_rd == 4'd2, "R2", "resume slot 1 word address", 32'(first_rd), 32'd2);
    check_all("R7"); nx = 4;

    // R6 ring-end marker
    clr(); put_desc(4, 2, 1, 0, 0, 1); put_desc(5, 2, 1, 1, 1, 1);
    put_desc(0, 3, 1, 0, 0, 1); put_owned(1);
    run(0);
    check_all("R6"); nx = 1;

    // random rounds (R4 R5 R6 R7 R8)
    for (int r = 0; r < 14; r++) begin
      int s, nf, nd, ln;
      clr(); s = nx;
      nf = 1 + ($urandom % 2);
      for (int f = 0; f < nf; f++) begin
        nd = 1 + ($urandom % 3);
        for (int d = 0; d < nd; d++) begin
          ln = $urandom % 7;
          if (d == nd - 1 && ln == 0) ln = 1;
          put_desc(s, ln, d == nd - 1, $urandom % 2, 0, d == 0);
          s = (s + 1) % N;
        end
      end
      put_owned(s);
      run(r % 3 == 0);
      check_all("R6");
      nx = s;
    end

    // R10 owned descriptor inside a frame
    clr(); put_desc(nx, 3, 0, 0, 0, 1); put_owned((nx + 1) % N);
    exp_ctrl[nx] = exp_ctrl[nx] | 32'h0800_0000;
    run(0);
    check_all("R10"); nx = (nx + 1) % N;

    // R9 starvation after two delivered bytes
    clr(); allow_lim = served + 2;
    put_desc(nx, 6, 1, 0, 0, 1); put_owned((nx + 1) % N);
    exp_n = 2; exp_ctrl[nx] = exp_ctrl[nx] | 32'h1000_0000;
    run(0);
    check_all("R9");
    allow_lim = 32'h7fff_ffff; nx = (nx + 1) % N;
    repeat (8) @(negedge clk);

    // R11 halt finishes the current frame and stops before the next
    begin
      int a, b;
      a = nx; b = (nx + 1) % N;
      clr(); put_desc(a, 6, 1, 0, 0, 1);
      record = 1'b0; put_desc(b, 3, 1, 1, 0, 1); record = 1'b1;
      put_owned((nx + 2) % N);
      rd_seen = 1'b0;
      pulse_start();
      while (!st_valid) @(negedge clk);
      tx_halt = 1'b1; @(negedge clk); tx_halt = 1'b0;
      chk(tx_go, "R11", "busy while frame finishes", {31'd0, tx_go}, 32'd1);
      wait_idle();
      check_all("R11");
      clr(); put_desc(b, 3, 1, 1, 0, 1); put_owned((nx + 2) % N);
      run(0);
      check_all("R11");
      nx = (nx + 2) % N;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule